// File: doc/BRIEF.md
# Buddy Block Allocator

This block hands out and takes back power-of-two regions of a fixed pool of equal-sized units. The regions are tracked in a binary tree held inside the block. A caller asks for a number of units. The block rounds that count up to the next power of two and finds a free region of that order. It then returns the first unit index of the region, or reports that no region fits. Freeing a region takes its first unit index and its order. The block marks the region free again and joins it with its buddy at each level where both halves are free.

Every tree node records the largest free order anywhere below it. This lets the search go from the root down to a suitable region, one level per cycle, taking the lower-addressed half whenever that half has room. After any change, the block walks back up to the root and refreshes each summary on the way. It handles one operation at a time. A busy output shows when an operation is in flight, and a one-cycle done pulse marks its end.

Top module: `buddy_alloc`

## Requirements
- R1: A request for n units (1 ≤ n ≤ 64) is served by a block of order k, where k is the smallest value with 2^k ≥ n. The returned base is a multiple of 2^k.
- R2: Placement is deterministic. From the root, the search takes the lower-addressed half whenever that half holds a free block of the needed order, and takes the upper half otherwise. The result is the lowest-addressed fitting block.
- R3: A request that cannot be met ends with done high and grant_ok low, and leaves the tree unchanged. This covers a request larger than the pool and a request larger than the largest free block.
- R4: When a freed block's buddy is also free, the two merge into a block of the next order. Merging repeats at each level up to the root, so a fully freed pool again reports one block of order 6.
- R5: A free is refused, with done and free_err high and the tree unchanged, in any of these cases: the given base and order do not name a currently allocated block, the base is not a multiple of 2^order, or the order exceeds 6.
- R6: largest_free reports the root summary. The code is 0 for no free block and k+1 for a largest free block of order k, so it reads 7 after reset.
- R7: While busy is high, request inputs are ignored, and each accepted request produces exactly one done pulse.
- R8: When alloc_req and free_req are both high on an idle cycle, the allocation is performed and the free is dropped.
- R9: done is a single-cycle pulse that occurs only with busy low. grant_ok, grant_base and free_err are valid while done is high.
- R10: A request for 0 units is treated as a request for 1 unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the whole pool becomes free |
| alloc_req | input | 1 | Start an allocation (sampled when idle) |
| alloc_units | input | 7 | Number of units requested |
| free_req | input | 1 | Start a free (sampled when idle, if no allocation) |
| free_base | input | 6 | First unit index of the block to free |
| free_order | input | 3 | Order of the block to free |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| grant_ok | output | 1 | Allocation succeeded (valid with done) |
| grant_base | output | 6 | Base unit index of the granted block |
| free_err | output | 1 | Free was refused (valid with done) |
| largest_free | output | 3 | Root summary: 0 none, k+1 for order k |

## Verification
The hardest case to reach is a cascade of merges up several levels. To get there, the pool must first be split unevenly, with blocks of different orders side by side. The pieces must then be released in an order that leaves each buddy pair free at a different moment. The stimulus builds that layout from a sequence of mixed-size allocations. It then frees the pieces smallest first, checks the merged size with a follow-up allocation, and checks largest_free returning to a whole pool. Refused frees are placed in the middle of this sequence, so a later allocation shows that they did not disturb the tree.

// File: rtl/buddy_pkg.sv
package buddy_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DESC, ST_UP} bstate_t;
endpackage

// File: rtl/buddy_order_calc.sv
// Rounds a unit count up to a power-of-two order; flags counts beyond the pool.
module buddy_order_calc #(
  parameter int LEVELS = 6,
  parameter int OW     = 3
) (
  input  logic [LEVELS:0] units,
  output logic [OW-1:0]   ord,
  output logic            too_big
);
  always_comb begin
    ord     = '0;
    too_big = (units > ((LEVELS+1)'(1) << LEVELS));
    for (int k = LEVELS; k >= 0; k--) begin
      if (units <= ((LEVELS+1)'(1) << k)) ord = OW'(k);
    end
  end
endmodule

// File: rtl/buddy_merge.sv
// Parent summary from two children: whole parent if both halves fully free.
module buddy_merge #(
  parameter int VW = 3
) (
  input  logic [VW-1:0] lv,
  input  logic [VW-1:0] rv,
  input  logic [VW-1:0] half_code,
  output logic [VW-1:0] pv
);
  always_comb begin
    if (lv == half_code && rv == half_code) pv = half_code + VW'(1);
    else if (lv > rv)                       pv = lv;
    else                                    pv = rv;
  end
endmodule

// File: rtl/buddy_alloc.sv
module buddy_alloc
  import buddy_pkg::*;
#(
  parameter int LEVELS = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          alloc_req,
  input  logic [LEVELS:0]               alloc_units,
  input  logic                          free_req,
  input  logic [LEVELS-1:0]             free_base,
  input  logic [$clog2(LEVELS+1)-1:0]   free_order,
  output logic                          busy,
  output logic                          done,
  output logic                          grant_ok,
  output logic [LEVELS-1:0]             grant_base,
  output logic                          free_err,
  output logic [$clog2(LEVELS+2)-1:0]   largest_free
);
  localparam int NODES = 2 ** (LEVELS + 1);
  localparam int IW    = LEVELS + 1;
  localparam int OW    = $clog2(LEVELS + 1);
  localparam int VW    = $clog2(LEVELS + 2);

  bstate_t           state;
  logic [IW-1:0]     idx;
  logic [OW-1:0]     cur_ord, tgt_ord;
  logic [LEVELS-1:0] base_r;
  logic              op_alloc;
  logic [VW-1:0]     avail [NODES];
  logic              used  [NODES];

  function automatic logic [VW-1:0] node_code(int i);
    logic [VW-1:0] c = '0;
    for (int d = 0; d <= LEVELS; d++)
      if (i >= (1 << d)) c = VW'(LEVELS - d + 1);
    return c;
  endfunction

  // request sizing
  logic [OW-1:0] req_ord;
  logic          req_big;
  buddy_order_calc #(.LEVELS(LEVELS), .OW(OW)) u_ord (
    .units(alloc_units), .ord(req_ord), .too_big(req_big)
  );
  logic can_fit;
  assign can_fit = !req_big && (avail[1] >= VW'(req_ord) + VW'(1));

  // free validation
  logic              f_ok_ord, f_aligned, f_valid;
  logic [OW-1:0]     f_shamt;
  logic [IW-1:0]     f_idx;
  logic [LEVELS-1:0] f_mask;
  always_comb begin
    f_ok_ord  = (free_order <= OW'(LEVELS));
    f_shamt   = OW'(LEVELS) - free_order;
    f_mask    = (LEVELS'(1) << free_order) - LEVELS'(1);
    f_aligned = ((free_base & f_mask) == '0);
    f_idx     = f_ok_ord ? ((IW'(1) << f_shamt) | IW'(free_base >> free_order)) : IW'(1);
    f_valid   = f_ok_ord && f_aligned && used[f_idx];
  end

  // descent
  logic [IW-1:0] lchild, rchild;
  logic          go_left;
  assign lchild  = {idx[IW-2:0], 1'b0};
  assign rchild  = {idx[IW-2:0], 1'b1};
  assign go_left = (avail[lchild] >= VW'(tgt_ord) + VW'(1));

  // ascent
  logic [IW-1:0] parent, pl, pr;
  logic [VW-1:0] pv;
  assign parent = idx >> 1;
  assign pl     = {parent[IW-2:0], 1'b0};
  assign pr     = {parent[IW-2:0], 1'b1};
  buddy_merge #(.VW(VW)) u_merge (
    .lv(avail[pl]), .rv(avail[pr]), .half_code(VW'(cur_ord) + VW'(1)), .pv(pv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      idx        <= IW'(1);
      cur_ord    <= '0;
      tgt_ord    <= '0;
      base_r     <= '0;
      op_alloc   <= 1'b0;
      done       <= 1'b0;
      grant_ok   <= 1'b0;
      grant_base <= '0;
      free_err   <= 1'b0;
      for (int i = 0; i < NODES; i++) begin
        avail[i] <= node_code(i);
        used[i]  <= 1'b0;
      end
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (alloc_req) begin
            op_alloc <= 1'b1;
            tgt_ord  <= req_ord;
            if (can_fit) begin
              state   <= ST_DESC;
              idx     <= IW'(1);
              cur_ord <= OW'(LEVELS);
              base_r  <= '0;
            end else begin
              done     <= 1'b1;
              grant_ok <= 1'b0;
              free_err <= 1'b0;
            end
          end else if (free_req) begin
            op_alloc <= 1'b0;
            if (f_valid) begin
              used[f_idx]  <= 1'b0;
              avail[f_idx] <= VW'(free_order) + VW'(1);
              idx          <= f_idx;
              cur_ord      <= free_order;
              state        <= ST_UP;
            end else begin
              done     <= 1'b1;
              free_err <= 1'b1;
              grant_ok <= 1'b0;
            end
          end
        end
        ST_DESC: begin
          if (cur_ord == tgt_ord) begin
            used[idx]  <= 1'b1;
            avail[idx] <= '0;
            grant_base <= base_r;
            state      <= ST_UP;
          end else begin
            if (go_left) idx <= lchild;
            else begin
              idx    <= rchild;
              base_r <= base_r | (LEVELS'(1) << (cur_ord - OW'(1)));
            end
            cur_ord <= cur_ord - OW'(1);
          end
        end
        ST_UP: begin
          if (idx == IW'(1)) begin
            state    <= ST_IDLE;
            done     <= 1'b1;
            grant_ok <= op_alloc;
            free_err <= 1'b0;
          end else begin
            avail[parent] <= pv;
            idx           <= parent;
            cur_ord       <= cur_ord + OW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (state != ST_IDLE);
  assign largest_free = avail[1];

  logic [LEVELS-1:0] t_mask;
  assign t_mask = (LEVELS'(1) << tgt_ord) - LEVELS'(1);

  assert_idle_on_done_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_aligned_grant_R1: assert property (@(posedge clk) disable iff (rst)
    (done && grant_ok) |-> ((grant_base & t_mask) == '0));
  assert_fail_keeps_tree_R3: assert property (@(posedge clk) disable iff (rst)
    (done && op_alloc && !grant_ok) |-> $stable(largest_free));
  assert_bad_free_keeps_tree_R5: assert property (@(posedge clk) disable iff (rst)
    (done && free_err) |-> $stable(largest_free));
  assert_descend_has_room_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DESC) |-> (avail[idx] >= VW'(tgt_ord) + VW'(1)));
endmodule

// File: tb/sim_buddy_alloc.sv
module sim_buddy_alloc;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       alloc_req;
  logic [6:0] alloc_units;
  logic       free_req;
  logic [5:0] free_base;
  logic [2:0] free_order;
  logic       busy, done, grant_ok, free_err;
  logic [5:0] grant_base;
  logic [2:0] largest_free;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  buddy_alloc #(.LEVELS(6)) u0 (
    .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_units(alloc_units),
    .free_req(free_req), .free_base(free_base), .free_order(free_order),
    .busy(busy), .done(done), .grant_ok(grant_ok), .grant_base(grant_base),
    .free_err(free_err), .largest_free(largest_free)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic do_alloc(input int units, output bit ok, output int base);
    @(negedge clk);
    alloc_req = 1'b1; alloc_units = units[6:0];
    @(negedge clk);
    alloc_req = 1'b0;
    wait_done();
    ok = grant_ok; base = int'(grant_base);
  endtask

  task automatic do_free(input int b, input int o, output bit err);
    @(negedge clk);
    free_req = 1'b1; free_base = b[5:0]; free_order = o[2:0];
    @(negedge clk);
    free_req = 1'b0;
    wait_done();
    err = free_err;
  endtask

  task automatic expect_alloc(input int units, input bit eok, input int ebase, input string req);
    bit ok; int base;
    do_alloc(units, ok, base);
    chk(ok == eok, req, ok, eok);
    if (eok) chk(base == ebase, req, base, ebase);
  endtask

  task automatic expect_free(input int b, input int o, input bit eerr, input string req);
    bit err;
    do_free(b, o, err);
    chk(err == eerr, req, err, eerr);
  endtask

  task automatic t_reset();
    chk(largest_free == 3'd7, "R6 reset root", largest_free, 7);
    chk(busy == 1'b0, "R9 reset busy", busy, 0);
    chk(done == 1'b0, "R9 reset done", done, 0);
  endtask

  task automatic t_rounding();
    expect_alloc(1, 1, 0, "R1 one unit");
    chk(largest_free == 3'd6, "R6 after split", largest_free, 6);
    expect_alloc(3, 1, 4, "R1 three units round to four");
    expect_alloc(2, 1, 2, "R2 lowest fitting pair");
    expect_alloc(0, 1, 1, "R10 zero units as one");
  endtask

  task automatic t_fail();
    expect_alloc(64, 0, 0, "R3 whole pool while split");
    chk(largest_free == 3'd6, "R3 tree kept", largest_free, 6);
    expect_alloc(65, 0, 0, "R3 larger than pool");
    expect_alloc(33, 0, 0, "R3 rounds past largest");
  endtask

  task automatic t_bad_free();
    expect_free(4, 1, 1, "R5 wrong order");
    expect_free(5, 2, 1, "R5 misaligned base");
    expect_free(8, 3, 1, "R5 never allocated");
    expect_free(0, 7, 1, "R5 order above pool");
    chk(largest_free == 3'd6, "R5 root kept", largest_free, 6);
    expect_free(4, 2, 0, "R5 real block still held");
    expect_alloc(4, 1, 4, "R2 reuse freed quad");
  endtask

  task automatic t_merge();
    expect_free(0, 0, 0, "R4 free unit 0");
    expect_free(1, 0, 0, "R4 free unit 1");
    expect_alloc(2, 1, 0, "R4 units merged to pair");
    expect_free(0, 1, 0, "R4 free pair 0");
    expect_free(2, 1, 0, "R4 free pair 2");
    expect_free(4, 2, 0, "R4 free quad 4");
    chk(largest_free == 3'd7, "R4 pool whole again", largest_free, 7);
    expect_free(4, 2, 1, "R5 double free");
  endtask

  task automatic t_busy();
    int extra = 0;
    bit seen_busy;
    @(negedge clk);
    alloc_req = 1'b1; alloc_units = 7'd1;
    @(negedge clk);
    seen_busy = busy;
    @(negedge clk);
    alloc_req = 1'b0;
    wait_done();
    chk(grant_ok && grant_base == 6'd0, "R7 first grant", grant_base, 0);
    chk(seen_busy, "R7 busy during op", seen_busy, 1);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk(extra == 0, "R7 single done", extra, 0);
    expect_alloc(1, 1, 1, "R7 held request ignored");
  endtask

  task automatic t_priority();
    @(negedge clk);
    alloc_req = 1'b1; alloc_units = 7'd1;
    free_req = 1'b1; free_base = 6'd0; free_order = 3'd0;
    @(negedge clk);
    alloc_req = 1'b0; free_req = 1'b0;
    wait_done();
    chk(grant_ok && grant_base == 6'd2, "R8 alloc wins", grant_base, 2);
    expect_free(0, 0, 0, "R8 free dropped");
    expect_free(1, 0, 0, "R8 cleanup 1");
    expect_free(2, 0, 0, "R8 cleanup 2");
    chk(largest_free == 3'd7, "R4 whole after cleanup", largest_free, 7);
  endtask

  task automatic t_full();
    expect_alloc(32, 1, 0, "R1 lower half");
    expect_alloc(32, 1, 32, "R2 upper half");
    chk(largest_free == 3'd0, "R6 none free", largest_free, 0);
    expect_alloc(1, 0, 0, "R3 pool exhausted");
    expect_free(32, 5, 0, "R4 free upper");
    expect_free(0, 5, 0, "R4 free lower");
    chk(largest_free == 3'd7, "R4 root merged", largest_free, 7);
    expect_alloc(64, 1, 0, "R1 whole pool");
    expect_free(0, 6, 0, "R4 free whole pool");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    rst = 1'b1; alloc_req = 1'b0; alloc_units = '0;
    free_req = 1'b0; free_base = '0; free_order = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_rounding();
    t_fail();
    t_bad_free();
    t_merge();
    t_busy();
    t_priority();
    t_full();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule